// File: doc/BRIEF.md
# Inter-Processor Interrupt Mailbox

This block lets the cores of a small multi-core cluster interrupt one another with short messages over an ordinary memory-mapped register bus. Every core owns a pair of 32-bit registers, a command register and a mailbox register, 8 bytes apart. A core posts a message by writing a target core index and a 16-bit payload into its own command register with the send bit set. The target then gets a level interrupt and finds the sender's index and the payload in its mailbox register. It clears the interrupt by writing its own command register with the clear bit set.

The sender is identified by the command register that was written, so software cannot claim to be another core. The bus is a simple register interface: valid, write, address, write data, and read data that is returned combinationally in the same cycle. Its port count is a parameter. With more than one port, several senders can target one core in the same cycle. A fixed arbiter then delivers the message from the lowest-numbered sender. The block has no interrupt inputs: register writes are its only stimulus.

Top module: `ipi_mailbox`

## Requirements
- R1: Core n's command register is at byte address 8*n and its mailbox register at 8*n+4. A mailbox read returns bit 31 = 0, bit 30 = pending, bits 29:16 = sender index, bits 15:0 = payload, and any bus port can read any core.
- R2: A write to command register n with bit 30 (send) set and bits 29:16 = d < NUM_CORES makes core d pending from the next clock edge. It also stores n as the sender and bits 15:0 as the payload, and drives irq_o[d] high.
- R3: irq_o[c] stays high for as long as core c is pending. Reads, and writes that neither clear core c nor target it, leave it unchanged.
- R4: A write to command register n with bit 31 (clear) set and no message for n in that cycle clears core n's pending flag and irq_o[n] on the next edge. The sender and payload fields keep their values.
- R5: A message to a core that is already pending replaces the sender and payload fields with the newest ones, and pending stays set.
- R6: When a clear for core n and a message to core n take effect in the same cycle, the message wins: pending stays set and the fields take the new message.
- R7: A send whose target index is NUM_CORES or above changes no core's state.
- R8: Command register reads return 0. Writes to mailbox registers are ignored. Accesses whose address bits 1:0 are not 00 are ignored and read as 0.
- R9: When several ports in one cycle send to the same core, the message from the lowest sender index is delivered and the others are dropped. Messages to different cores in the same cycle are all delivered.
- R10: A synchronous active-high reset clears every pending flag, sender field and payload field, and drives all irq_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| bus_valid_i | input | NUM_PORTS | Access request, one bit per port |
| bus_write_i | input | NUM_PORTS | 1 = write, 0 = read, one bit per port |
| bus_addr_i | input | NUM_PORTS*ADDR_W | Byte address, port p in slice p |
| bus_wdata_i | input | NUM_PORTS*32 | Write data, port p in slice p |
| bus_rdata_o | output | NUM_PORTS*32 | Read data in the same cycle, 0 when the port is not reading a mailbox |
| irq_o | output | NUM_CORES | Level interrupt per core |

## Verification
On every cycle the assertions check four things. An interrupt line can rise only after a delivery to that core, and can fall only after a clear for that core or a reset. A delivery always raises the target's line. The arbiter grants at most one port per target. The bench's scenarios cover what depends on data values and ordering: the sender and payload fields seen in the mailbox, overwrite of a pending message, a clear and a message to the same core in one cycle, out-of-range targets, misaligned and mailbox writes, and the sender-index priority between two ports.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
   localparam int MAX_CORES  = 16384;
   localparam int IDX_BITS   = 14;
   localparam int DATA_BITS  = 16;
   localparam int CLR_BIT    = 31;
   localparam int SEND_BIT   = 30;
   localparam int PEND_BIT   = 30;
   localparam int IDX_LSB    = 16;

   typedef struct packed {
      logic                 vld;
      logic [IDX_BITS-1:0]  dst;
      logic [IDX_BITS-1:0]  src;
      logic [DATA_BITS-1:0] data;
   } send_req_t;

   function automatic logic [31:0] mbox_word(input logic pend,
                                             input logic [IDX_BITS-1:0] src,
                                             input logic [DATA_BITS-1:0] data);
      return {1'b0, pend, src, data};
   endfunction
endpackage

// File: rtl/ipi_port_decode.sv
module ipi_port_decode
   import ipi_pkg::*;
#(
   parameter int NUM_CORES = 4,
   parameter int CW        = 2,
   parameter int ADDR_W    = 5
) (
   input  logic              valid_i,
   input  logic              write_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [31:0]       wdata_i,
   output send_req_t         send_o,
   output logic              clr_vld_o,
   output logic [CW-1:0]     clr_core_o,
   output logic              rd_vld_o,
   output logic [CW-1:0]     rd_core_o
);
   logic [CW-1:0] idx;
   logic          hit;
   logic          is_mbox;
   logic          cmd_wr;
   logic [IDX_BITS-1:0] dst;

   assign idx     = addr_i[ADDR_W-1:3];
   assign is_mbox = addr_i[2];
   assign hit     = valid_i && (addr_i[1:0] == 2'b00) && (int'(idx) < NUM_CORES);
   assign cmd_wr  = hit && write_i && !is_mbox;
   assign dst     = wdata_i[IDX_LSB +: IDX_BITS];

   always_comb begin
      send_o.vld  = cmd_wr && wdata_i[SEND_BIT] && (int'(dst) < NUM_CORES);
      send_o.dst  = dst;
      send_o.src  = IDX_BITS'(idx);
      send_o.data = wdata_i[DATA_BITS-1:0];
   end

   assign clr_vld_o  = cmd_wr && wdata_i[CLR_BIT];
   assign clr_core_o = idx;
   assign rd_vld_o   = hit && !write_i && is_mbox;
   assign rd_core_o  = idx;
endmodule

// File: rtl/ipi_dest_arb.sv
module ipi_dest_arb
   import ipi_pkg::*;
#(
   parameter int NUM_CORES = 4,
   parameter int NUM_PORTS = 1
) (
   input  send_req_t            req_i   [NUM_PORTS],
   output logic [NUM_CORES-1:0] win_vld_o,
   output logic [IDX_BITS-1:0]  win_src_o  [NUM_CORES],
   output logic [DATA_BITS-1:0] win_data_o [NUM_CORES],
   output logic [NUM_CORES*NUM_PORTS-1:0] grant_o
);
   generate
      if (NUM_PORTS == 1) begin : g_single
         for (genvar d = 0; d < NUM_CORES; d++) begin : g_dst
            assign grant_o[d]    = req_i[0].vld && (int'(req_i[0].dst) == d);
            assign win_vld_o[d]  = grant_o[d];
            assign win_src_o[d]  = req_i[0].src;
            assign win_data_o[d] = req_i[0].data;
         end
      end else begin : g_multi
         for (genvar d = 0; d < NUM_CORES; d++) begin : g_dst
            always_comb begin
               logic                found;
               logic [IDX_BITS-1:0] best;
               int                  sel;
               found = 1'b0;
               best  = '0;
               sel   = 0;
               for (int p = 0; p < NUM_PORTS; p++) begin
                  if (req_i[p].vld && (int'(req_i[p].dst) == d) &&
                      (!found || (req_i[p].src < best))) begin
                     found = 1'b1;
                     best  = req_i[p].src;
                     sel   = p;
                  end
               end
               win_vld_o[d]  = found;
               win_src_o[d]  = best;
               win_data_o[d] = req_i[sel].data;
               for (int p = 0; p < NUM_PORTS; p++) begin
                  grant_o[d*NUM_PORTS + p] = found && (sel == p);
               end
            end
         end
      end
   endgenerate
endmodule

// File: rtl/ipi_core_slot.sv
module ipi_core_slot
   import ipi_pkg::*;
(
   input  logic                 clk_i,
   input  logic                 rst_i,
   input  logic                 deliver_i,
   input  logic [IDX_BITS-1:0]  src_i,
   input  logic [DATA_BITS-1:0] data_i,
   input  logic                 clr_i,
   output logic                 pend_o,
   output logic [31:0]          word_o
);
   logic                 pend_q;
   logic [IDX_BITS-1:0]  src_q;
   logic [DATA_BITS-1:0] data_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         pend_q <= 1'b0;
         src_q  <= '0;
         data_q <= '0;
      end else if (deliver_i) begin
         pend_q <= 1'b1;
         src_q  <= src_i;
         data_q <= data_i;
      end else if (clr_i) begin
         pend_q <= 1'b0;
      end
   end

   assign pend_o = pend_q;
   assign word_o = mbox_word(pend_q, src_q, data_q);
endmodule

// File: rtl/ipi_mailbox.sv
module ipi_mailbox
   import ipi_pkg::*;
#(
   parameter int NUM_CORES = 4,
   parameter int NUM_PORTS = 1,
   parameter int CW        = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
   parameter int ADDR_W    = CW + 3
) (
   input  logic                        clk_i,
   input  logic                        rst_i,
   input  logic [NUM_PORTS-1:0]        bus_valid_i,
   input  logic [NUM_PORTS-1:0]        bus_write_i,
   input  logic [NUM_PORTS*ADDR_W-1:0] bus_addr_i,
   input  logic [NUM_PORTS*32-1:0]     bus_wdata_i,
   output logic [NUM_PORTS*32-1:0]     bus_rdata_o,
   output logic [NUM_CORES-1:0]        irq_o
);
   generate
      if (NUM_CORES < 1 || NUM_CORES > MAX_CORES) begin : g_bad_cores
         $error("ipi_mailbox: NUM_CORES out of range");
      end
      if (NUM_PORTS < 1) begin : g_bad_ports
         $error("ipi_mailbox: NUM_PORTS must be at least 1");
      end
      if (ADDR_W != CW + 3) begin : g_bad_addr
         $error("ipi_mailbox: ADDR_W must equal CW + 3");
      end
   endgenerate

   send_req_t              send     [NUM_PORTS];
   logic [NUM_PORTS-1:0]   clr_vld;
   logic [CW-1:0]          clr_core [NUM_PORTS];
   logic [NUM_PORTS-1:0]   rd_vld;
   logic [CW-1:0]          rd_core  [NUM_PORTS];

   logic [NUM_CORES-1:0]   win_vld;
   logic [IDX_BITS-1:0]    win_src  [NUM_CORES];
   logic [DATA_BITS-1:0]   win_data [NUM_CORES];
   logic [NUM_CORES*NUM_PORTS-1:0] grant;
   logic [NUM_CORES-1:0]   ack_vec;
   logic [NUM_CORES-1:0]   pend;
   logic [31:0]            mbox     [NUM_CORES];

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      ipi_port_decode #(
         .NUM_CORES (NUM_CORES),
         .CW        (CW),
         .ADDR_W    (ADDR_W)
      ) u_dec (
         .valid_i    (bus_valid_i[p]),
         .write_i    (bus_write_i[p]),
         .addr_i     (bus_addr_i[p*ADDR_W +: ADDR_W]),
         .wdata_i    (bus_wdata_i[p*32 +: 32]),
         .send_o     (send[p]),
         .clr_vld_o  (clr_vld[p]),
         .clr_core_o (clr_core[p]),
         .rd_vld_o   (rd_vld[p]),
         .rd_core_o  (rd_core[p])
      );

      assign bus_rdata_o[p*32 +: 32] = rd_vld[p] ? mbox[rd_core[p]] : 32'h0;
   end

   ipi_dest_arb #(
      .NUM_CORES (NUM_CORES),
      .NUM_PORTS (NUM_PORTS)
   ) u_arb (
      .req_i      (send),
      .win_vld_o  (win_vld),
      .win_src_o  (win_src),
      .win_data_o (win_data),
      .grant_o    (grant)
   );

   always_comb begin
      ack_vec = '0;
      for (int p = 0; p < NUM_PORTS; p++) begin
         if (clr_vld[p]) ack_vec[clr_core[p]] = 1'b1;
      end
   end

   for (genvar c = 0; c < NUM_CORES; c++) begin : g_slot
      ipi_core_slot u_slot (
         .clk_i     (clk_i),
         .rst_i     (rst_i),
         .deliver_i (win_vld[c]),
         .src_i     (win_src[c]),
         .data_i    (win_data[c]),
         .clr_i     (ack_vec[c]),
         .pend_o    (pend[c]),
         .word_o    (mbox[c])
      );
   end

   assign irq_o = pend;
endmodule

// File: rtl/ipi_mailbox_chk.sv
module ipi_mailbox_chk #(
   parameter int NUM_CORES = 4,
   parameter int NUM_PORTS = 1
) (
   input logic                           clk_i,
   input logic                           rst_i,
   input logic [NUM_CORES-1:0]           irq_o,
   input logic [NUM_CORES-1:0]           win_vld,
   input logic [NUM_CORES-1:0]           ack_vec,
   input logic [NUM_CORES*NUM_PORTS-1:0] grant
);
   // R10
   reset_clear_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      $past(rst_i) |-> (irq_o == '0));

   // R2
   irq_rise_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      !$past(rst_i) |-> ((irq_o & ~$past(irq_o) & ~$past(win_vld)) == '0));

   // R3
   irq_fall_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      !$past(rst_i) |-> ((~irq_o & $past(irq_o) & ~$past(ack_vec)) == '0));

   // R6
   deliver_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (win_vld != '0) |=> ((irq_o & $past(win_vld)) == $past(win_vld)));

   for (genvar d = 0; d < NUM_CORES; d++) begin : g_dst
      // R9
      one_grant_chk: assert property (@(posedge clk_i) disable iff (rst_i)
         $onehot0(grant[d*NUM_PORTS +: NUM_PORTS]));
   end
endmodule

bind ipi_mailbox ipi_mailbox_chk #(
   .NUM_CORES (NUM_CORES),
   .NUM_PORTS (NUM_PORTS)
) u_chk (
   .clk_i   (clk_i),
   .rst_i   (rst_i),
   .irq_o   (irq_o),
   .win_vld (win_vld),
   .ack_vec (ack_vec),
   .grant   (grant)
);

// File: tb/tb_ipi_mailbox.sv
module tb_ipi_mailbox;
   localparam int N  = 4;
   localparam int P  = 2;
   localparam int CW = 2;
   localparam int AW = CW + 3;

   logic             clk = 1'b0;
   logic             rst = 1'b1;
   logic [P-1:0]     valid = '0;
   logic [P-1:0]     wr = '0;
   logic [P*AW-1:0]  addr = '0;
   logic [P*32-1:0]  wdata = '0;
   logic [P*32-1:0]  rdata;
   logic [N-1:0]     irq;

   int vectors = 0;
   int miscompares = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   ipi_mailbox #(.NUM_CORES(N), .NUM_PORTS(P)) dut (
      .clk_i       (clk),
      .rst_i       (rst),
      .bus_valid_i (valid),
      .bus_write_i (wr),
      .bus_addr_i  (addr),
      .bus_wdata_i (wdata),
      .bus_rdata_o (rdata),
      .irq_o       (irq)
   );

   typedef struct {
      int          core;
      logic [31:0] exp;
      string       req;
   } item_t;
   item_t sb[$];

   function automatic logic [AW-1:0] cmd_a(int n);
      return AW'(8 * n);
   endfunction
   function automatic logic [AW-1:0] mbx_a(int n);
      return AW'(8 * n + 4);
   endfunction

   task automatic check(string req, logic [31:0] got, logic [31:0] exp);
      vectors++;
      if (got !== exp) begin
         miscompares++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic bus_write(int p, logic [AW-1:0] a, logic [31:0] d);
      @(negedge clk);
      valid[p] = 1'b1; wr[p] = 1'b1;
      addr[p*AW +: AW] = a; wdata[p*32 +: 32] = d;
      @(negedge clk);
      valid[p] = 1'b0; wr[p] = 1'b0;
   endtask

   task automatic bus_write2(logic [AW-1:0] a0, logic [31:0] d0,
                             logic [AW-1:0] a1, logic [31:0] d1);
      @(negedge clk);
      valid = 2'b11; wr = 2'b11;
      addr = {a1, a0}; wdata = {d1, d0};
      @(negedge clk);
      valid = '0; wr = '0;
   endtask

   task automatic bus_read(int p, logic [AW-1:0] a, output logic [31:0] d);
      @(negedge clk);
      valid[p] = 1'b1; wr[p] = 1'b0; addr[p*AW +: AW] = a;
      #2;
      d = rdata[p*32 +: 32];
      valid[p] = 1'b0;
   endtask

   task automatic expect_mbox(int core, logic [31:0] exp, string req);
      item_t it;
      it.core = core; it.exp = exp; it.req = req;
      sb.push_back(it);
   endtask

   // monitor side of the scoreboard: reads each expected mailbox and the line
   task automatic drain();
      logic [31:0] got;
      while (sb.size() > 0) begin
         item_t it;
         it = sb.pop_front();
         bus_read(0, mbx_a(it.core), got);
         check(it.req, got, it.exp);
         check({it.req, " irq"}, {31'h0, irq[it.core]}, {31'h0, it.exp[30]});
      end
   endtask

   initial begin
      logic [31:0] got;
      repeat (3) @(negedge clk);
      rst = 1'b0;

      // R10 state after reset
      check("R10 irq", {28'h0, irq}, 32'h0);
      for (int c = 0; c < N; c++) expect_mbox(c, 32'h0, "R10");
      drain();

      // R2 core1 -> core2
      bus_write(0, cmd_a(1), 32'h4002_BEEF);
      check("R2 irq vector", {28'h0, irq}, 32'h4);
      expect_mbox(2, 32'h4001_BEEF, "R2");
      drain();

      // R1 read from the second port
      bus_read(1, mbx_a(2), got);
      check("R1 port1 read", got, 32'h4001_BEEF);

      // R8 command read, mailbox write, misaligned write
      bus_read(0, cmd_a(2), got);
      check("R8 cmd read", got, 32'h0);
      bus_write(0, mbx_a(2), 32'hFFFF_FFFF);
      bus_write(0, AW'(8 * 2 + 1), 32'h8000_0000);
      bus_read(0, AW'(8 * 2 + 5), got);
      check("R8 misaligned read", got, 32'h0);
      // R3 still pending after unrelated traffic
      expect_mbox(2, 32'h4001_BEEF, "R3/R8");
      drain();

      // R5 overwrite by core3
      bus_write(0, cmd_a(3), 32'h4002_1234);
      expect_mbox(2, 32'h4003_1234, "R5");
      drain();

      // R4 clear keeps fields
      bus_write(0, cmd_a(2), 32'h8000_0000);
      check("R4 irq vector", {28'h0, irq}, 32'h0);
      expect_mbox(2, 32'h0003_1234, "R4");
      drain();

      // R7 out-of-range targets
      bus_write(0, cmd_a(0), 32'h4004_1111);
      bus_write(0, cmd_a(0), 32'h7FFF_2222);
      check("R7 irq vector", {28'h0, irq}, 32'h0);
      expect_mbox(0, 32'h0, "R7");
      expect_mbox(3, 32'h0, "R7");
      drain();

      // R6 clear and message in the same cycle
      bus_write(0, cmd_a(1), 32'h4000_0A0A);
      expect_mbox(0, 32'h4001_0A0A, "R6 setup");
      drain();
      bus_write(0, cmd_a(0), 32'hC000_5555);
      expect_mbox(0, 32'h4000_5555, "R6");
      drain();
      bus_write(0, cmd_a(0), 32'h8000_0000);
      expect_mbox(0, 32'h0000_5555, "R4 after R6");
      drain();

      // R9 two ports to core1: sender 2 beats sender 3
      bus_write2(cmd_a(3), 32'h4001_1111, cmd_a(2), 32'h4001_2222);
      expect_mbox(1, 32'h4002_2222, "R9 low sender on port1");
      drain();
      bus_write(0, cmd_a(1), 32'h8000_0000);
      bus_write2(cmd_a(2), 32'h4001_3333, cmd_a(0), 32'h4001_4444);
      expect_mbox(1, 32'h4000_4444, "R9 low sender on port1 again");
      drain();
      bus_write2(cmd_a(0), 32'h4002_5678, cmd_a(1), 32'h4003_9ABC);
      expect_mbox(2, 32'h4000_5678, "R9 distinct targets");
      expect_mbox(3, 32'h4001_9ABC, "R9 distinct targets");
      drain();

      // R10 reset mid-run
      @(negedge clk); rst = 1'b1;
      @(negedge clk); rst = 1'b0;
      check("R10 irq after reset", {28'h0, irq}, 32'h0);
      for (int c = 0; c < N; c++) expect_mbox(c, 32'h0, "R10 mid-run");
      drain();

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end
endmodule